// File: doc/BRIEF.md
# Serial Encoder-Link Transmitter

This block drives the transmit side of a clocked serial link such as a position-encoder interface. A host writes bytes into a 32-bit bit-level FIFO and then strobes `go`. The block shifts the FIFO contents onto `tx_data` least-significant bit first. It produces a matching bit clock on `tx_clk` whose period comes from a divider of the system clock. Between frames the data line rests high and the bit clock rests low.

The frame length is set in bits and is captured when `go` is accepted. A non-zero length gives a fixed-size frame, and every bit of that frame is expected to be in the FIFO before the start. A length of zero gives an open-ended stream instead. In that mode the host watches `fill_level` and keeps topping up the FIFO a byte at a time while the line runs. The stream finishes once the host drops `stream_en` and the FIFO has drained.

Both underrun and overrun set sticky flags, and each flag has its own write-one-to-clear input. A single-cycle `done` pulse marks the end of every frame.

The byte port uses valid/ready, with one difference from the usual rule. `s_ready` is high whenever at least 8 bits of the FIFO are free. A source must raise `s_valid` only while `s_ready` is high. A beat offered while `s_ready` is low is not held waiting: it is dropped, and it counts as an overrun.

Top module: `enc_link_tx`

## Requirements
- R1: While no frame is active, `tx_data` is 1, `tx_clk` is 0 and `busy` is 0. After reset, `fill_level` is 0, `s_ready` is 1 and both error flags are 0.
- R2: A byte is accepted in every cycle with `s_valid` and `s_ready` both high. `s_ready` is high exactly when `fill_level` is 24 or less. `fill_level` counts bits from 0 to 32, and each accepted byte adds 8 to it.
- R3: If `s_valid` is high while `s_ready` is low, the byte is discarded, `fill_level` does not move, and `err_overrun` reads 1 from the next cycle.
- R4: `go` starts a frame only while `busy` is 0, and `busy` rises on the next cycle. A `go` that arrives during a frame is ignored.
- R5: Bits go out in the order they were pushed, and bit 0 of each byte goes first. `tx_data` does not change while `tx_clk` is high, so a receiver samples on the rising edge of `tx_clk`.
- R6: Each bit lasts 2*(`cfg_div`+1) system clocks, using the `cfg_div` value captured at `go`. `tx_clk` rises halfway through each bit and toggles only while `busy` is 1.
- R7: For a `cfg_len` from 1 to 32, exactly that many bits are sent and removed from the FIFO. Any value above 32 is treated as 32.
- R8: If a fixed-length frame reaches a bit while the FIFO is empty, it sends 1 for that bit and sets `err_underrun`. The frame still runs to its full length.
- R9: `cfg_len` of 0 selects streaming. The frame keeps going while the FIFO holds bits. It ends at the next mid-bit point at which no bit was available.
- R10: A stream that finds no bit while `stream_en` is still high sets `err_underrun`. When `stream_en` is low, the same ending is a normal finish and sets nothing.
- R11: Error flags stay set until a 1 on `clr_underrun` or `clr_overrun`. A new error in the same cycle as a clear wins.
- R12: `done` is a one-cycle pulse issued in the cycle `busy` falls, once for every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len | input | 6 | Frame length in bits; 0 selects streaming |
| cfg_div | input | 8 | Bit-clock half-period minus one, in system clocks |
| go | input | 1 | Start strobe |
| stream_en | input | 1 | Host still feeding a stream |
| s_valid | input | 1 | Byte offered |
| s_data | input | 8 | Byte, bit 0 sent first |
| s_ready | output | 1 | At least 8 bits free |
| fill_level | output | 6 | Bits held in the FIFO, 0 to 32 |
| tx_clk | output | 1 | Bit clock |
| tx_data | output | 1 | Serial data line |
| busy | output | 1 | Frame active |
| done | output | 1 | One-cycle end-of-frame pulse |
| err_underrun | output | 1 | Sticky underrun flag |
| err_overrun | output | 1 | Sticky overrun flag |
| clr_underrun | input | 1 | Write-one-to-clear for underrun |
| clr_overrun | input | 1 | Write-one-to-clear for overrun |

## Verification
Random fixed-length frames are run with leftover bits carried over from earlier frames. A design that popped one bit too many or too few would show up as a shifted bit stream and a wrong `fill_level`. A streaming transfer is refilled at the `s_ready` boundary while it runs. A FIFO that mishandled a push landing in the same cycle as a pop would corrupt or lose bits there. Directed cases cover the rest: a push into a full FIFO, which a wrong design would store or leave unflagged; a length above 32, which a wrong design would treat modulo 32; an empty FIFO part-way through a fixed frame, which must send ones, raise the flag and still complete; and a streaming drain with `stream_en` both high and low, which tells a starved stream apart from a normal finish.

// File: rtl/enc_tx_pkg.sv
package enc_tx_pkg;
  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_SHIFT = 1'b1
  } tx_state_e;

  localparam int ERR_UNDER = 0;
  localparam int ERR_OVER  = 1;
  localparam int ERR_N     = 2;
endpackage

// File: rtl/tx_bit_fifo.sv
// Bit-granular FIFO: byte-wide writes, single-bit reads from bit 0.
module tx_bit_fifo #(
  parameter int DEPTH  = 32,
  parameter int PUSH_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PUSH_W-1:0] push_data,
  input  logic              pop,
  output logic              head,
  output logic [CNT_W-1:0]  count,
  output logic              room
);
  logic [DEPTH-1:0] mem_q, mem_d, shifted, ins, msk;
  logic [CNT_W-1:0] pos, cnt_d;

  always_comb begin
    shifted = pop ? (mem_q >> 1) : mem_q;
    pos     = count - CNT_W'(pop);
    ins     = {{(DEPTH-PUSH_W){1'b0}}, push_data} << pos;
    msk     = {{(DEPTH-PUSH_W){1'b0}}, {PUSH_W{1'b1}}} << pos;
    mem_d   = push ? ((shifted & ~msk) | ins) : shifted;
    cnt_d   = count - CNT_W'(pop) + (push ? CNT_W'(PUSH_W) : CNT_W'(0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
      count <= '0;
    end else begin
      mem_q <= mem_d;
      count <= cnt_d;
    end
  end

  assign head = mem_q[0];
  assign room = (count <= CNT_W'(DEPTH - PUSH_W));
endmodule

// File: rtl/tx_bitclk_div.sv
// Emits a one-cycle tick every DIV+1 system clocks while run is high.
module tx_bitclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/tx_err_flags.sv
// Sticky flags; a set in the same cycle as a clear wins.
module tx_err_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;
      else if (clr[g]) flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_frame_seq.sv
// Frame sequencer: holds the bit on the line, drives the bit clock,
// counts fixed frames and detects starvation.
module tx_frame_seq
  import enc_tx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DIV_W = 8,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             stream_en,
  input  logic             tick,
  input  logic             fifo_has,
  input  logic             fifo_head,
  output logic [DIV_W-1:0] div_q,
  output logic             pop,
  output logic             tx_clk,
  output logic             tx_data,
  output logic             busy,
  output logic             done,
  output logic             underrun_set
);
  tx_state_e        state_q;
  logic             cont_q, bit_ok_q;
  logic [LEN_W-1:0] left_q, len_eff;
  logic             start, rise, fall, last_bit;

  assign len_eff  = (cfg_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : cfg_len;
  assign busy     = (state_q == TX_SHIFT);
  assign start    = !busy && go;
  assign rise     = busy && tick && !tx_clk;
  assign fall     = busy && tick && tx_clk;
  assign last_bit = !cont_q && (left_q == LEN_W'(1));

  assign pop = fifo_has && (start || (fall && !last_bit));

  assign underrun_set = rise && !bit_ok_q && (!cont_q || stream_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= TX_IDLE;
      cont_q   <= 1'b0;
      bit_ok_q <= 1'b0;
      left_q   <= '0;
      div_q    <= '0;
      tx_clk   <= 1'b0;
      tx_data  <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state_q  <= TX_SHIFT;
        cont_q   <= (cfg_len == '0);
        left_q   <= len_eff;
        div_q    <= cfg_div;
        tx_clk   <= 1'b0;
        tx_data  <= fifo_has ? fifo_head : 1'b1;
        bit_ok_q <= fifo_has;
      end else if (rise) begin
        if (cont_q && !bit_ok_q) begin
          state_q <= TX_IDLE;
          tx_data <= 1'b1;
          done    <= 1'b1;
        end else begin
          tx_clk <= 1'b1;
        end
      end else if (fall) begin
        tx_clk <= 1'b0;
        if (last_bit) begin
          state_q <= TX_IDLE;
          tx_data <= 1'b1;
          done    <= 1'b1;
        end else begin
          if (!cont_q) left_q <= left_q - LEN_W'(1);
          tx_data  <= fifo_has ? fifo_head : 1'b1;
          bit_ok_q <= fifo_has;
        end
      end
    end
  end
endmodule

// File: rtl/enc_link_tx.sv
module enc_link_tx
  import enc_tx_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int PUSH_W = 8,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              go,
  input  logic              stream_en,
  input  logic              s_valid,
  input  logic [PUSH_W-1:0] s_data,
  output logic              s_ready,
  output logic [LEN_W-1:0]  fill_level,
  output logic              tx_clk,
  output logic              tx_data,
  output logic              busy,
  output logic              done,
  output logic              err_underrun,
  output logic              err_overrun,
  input  logic              clr_underrun,
  input  logic              clr_overrun
);
  logic             room, head, pop, push, tick, under_set;
  logic [DIV_W-1:0] div_q;
  logic [ERR_N-1:0] err_set, err_clr, err_q;

  assign push    = s_valid && room;
  assign s_ready = room;

  tx_bit_fifo #(.DEPTH(DEPTH), .PUSH_W(PUSH_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(s_data),
    .pop(pop), .head(head), .count(fill_level), .room(room)
  );

  tx_bitclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  tx_frame_seq #(.DEPTH(DEPTH), .DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .cfg_len(cfg_len), .cfg_div(cfg_div),
    .stream_en(stream_en), .tick(tick), .fifo_has(fill_level != '0),
    .fifo_head(head), .div_q(div_q), .pop(pop), .tx_clk(tx_clk),
    .tx_data(tx_data), .busy(busy), .done(done), .underrun_set(under_set)
  );

  always_comb begin
    err_set            = '0;
    err_clr            = '0;
    err_set[ERR_UNDER] = under_set;
    err_set[ERR_OVER]  = s_valid && !room;
    err_clr[ERR_UNDER] = clr_underrun;
    err_clr[ERR_OVER]  = clr_overrun;
  end

  tx_err_flags #(.N(ERR_N)) u_err (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr), .flags(err_q)
  );

  assign err_underrun = err_q[ERR_UNDER];
  assign err_overrun  = err_q[ERR_OVER];
endmodule

// File: rtl/enc_link_tx_chk.sv
module enc_link_tx_chk #(
  parameter int DEPTH  = 32,
  parameter int PUSH_W = 8,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             s_valid,
  input logic             s_ready,
  input logic [LEN_W-1:0] fill_level,
  input logic             tx_clk,
  input logic             tx_data,
  input logic             busy,
  input logic             done,
  input logic             err_underrun,
  input logic             err_overrun,
  input logic             clr_underrun,
  input logic             clr_overrun
);
  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_data && !tx_clk));

  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LEN_W'(DEPTH));

  p_push_adds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !busy && !go) |=>
      (fill_level == $past(fill_level) + LEN_W'(PUSH_W)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> err_overrun);

  p_drop_keeps_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready && !busy && !go) |=> (fill_level == $past(fill_level)));

  p_go_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> busy);

  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clk && $past(tx_clk)) |-> $stable(tx_data));

  p_clk_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clk |-> busy);

  p_under_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_underrun && !clr_underrun) |=> err_underrun);

  p_over_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overrun && !clr_overrun) |=> err_overrun);

  p_over_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_overrun && !(s_valid && !s_ready)) |=> !err_overrun);

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind enc_link_tx enc_link_tx_chk #(.DEPTH(DEPTH), .PUSH_W(PUSH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .s_valid(s_valid), .s_ready(s_ready),
  .fill_level(fill_level), .tx_clk(tx_clk), .tx_data(tx_data), .busy(busy),
  .done(done), .err_underrun(err_underrun), .err_overrun(err_overrun),
  .clr_underrun(clr_underrun), .clr_overrun(clr_overrun)
);

// File: tb/test_enc_link_tx.sv
`timescale 1ns/1ps
module test_enc_link_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cfg_len = '0;
  logic [7:0] cfg_div = '0;
  logic       go = 1'b0, stream_en = 1'b0, s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic       clr_underrun = 1'b0, clr_overrun = 1'b0;
  logic       s_ready, tx_clk, tx_data, busy, done, err_underrun, err_overrun;
  logic [5:0] fill_level;

  always #10 clk = ~clk;

  enc_link_tx i_enc_link_tx (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_div(cfg_div), .go(go),
    .stream_en(stream_en), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .fill_level(fill_level), .tx_clk(tx_clk), .tx_data(tx_data), .busy(busy),
    .done(done), .err_underrun(err_underrun), .err_overrun(err_overrun),
    .clr_underrun(clr_underrun), .clr_overrun(clr_overrun)
  );

  int checks = 0, failures = 0;
  bit exp_q[$];
  bit cap_q[$];
  int cyc = 0, last_rise = 0, per_bad = 0, idle_viol = 0, done_cnt = 0;
  int cur_div = 0;
  bit have_rise = 0, clk_prev = 0;

  function automatic int exp_period(int div);
    return 2 * (div + 1);
  endfunction

  function automatic int eff_len(int len);
    return (len > 32) ? 32 : len;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: samples away from the rising clock edge.
  always @(negedge clk) begin
    cyc++;
    if (tx_clk && !clk_prev) begin
      cap_q.push_back(tx_data);
      if (have_rise && (cyc - last_rise) != exp_period(cur_div)) per_bad++;
      have_rise = 1;
      last_rise = cyc;
    end
    if (!busy) have_rise = 0;
    if (tx_clk && !busy) idle_viol++;
    if (done) done_cnt++;
    clk_prev = tx_clk;
  end

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = b;
    if (s_ready) for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  // Compare captured bits against the expected list; count as one check.
  task automatic cmp_bits(string req, bit expv[$]);
    int bad = -1;
    if (cap_q.size() != expv.size()) begin
      chk(0, {req, " bit count"}, cap_q.size(), expv.size());
    end else begin
      foreach (expv[i]) if (bad < 0 && cap_q[i] != expv[i]) bad = i;
      chk(bad < 0, {req, " bit value"}, (bad < 0) ? 0 : int'(cap_q[bad]),
          (bad < 0) ? 0 : int'(expv[bad]));
    end
  endtask

  task automatic run_fixed(int len, int div, string req);
    bit expv[$];
    cap_q.delete();
    per_bad = 0;
    cfg_len = 6'(len);
    cfg_div = 8'(div);
    cur_div = div;
    for (int i = 0; i < eff_len(len); i++)
      expv.push_back(exp_q.size() > 0 ? exp_q.pop_front() : 1'b1);
    pulse_go();
    wait_done();
    cmp_bits(req, expv);
    chk(per_bad == 0, "R6 bit period", per_bad, 0);
    chk(fill_level == 6'(exp_q.size()), "R7 fill after frame", fill_level, exp_q.size());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_71));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(tx_data == 1'b1, "R1 tx_data idle", tx_data, 1);
    chk(tx_clk == 1'b0, "R1 tx_clk idle", tx_clk, 0);
    chk(fill_level == 0 && s_ready == 1'b1, "R1 fill/ready", fill_level, 0);
    chk(!err_underrun && !err_overrun && !busy, "R1 flags", err_underrun + err_overrun, 0);

    // R2 fill accounting and ready threshold
    for (int i = 0; i < 4; i++) begin
      push_byte(8'($urandom));
      chk(fill_level == 6'(8 * (i + 1)), "R2 fill per byte", fill_level, 8 * (i + 1));
    end
    chk(s_ready == 1'b0, "R2 ready low at 32", s_ready, 0);

    // R3 overflow: push into full FIFO is dropped and flagged
    push_byte(8'hA5);
    chk(fill_level == 6'd32, "R3 fill unchanged", fill_level, 32);
    chk(err_overrun == 1'b1, "R3 overrun flag", err_overrun, 1);
    // R11 clear
    @(negedge clk); clr_overrun = 1'b1; @(negedge clk); clr_overrun = 1'b0;
    chk(err_overrun == 1'b0, "R11 overrun cleared", err_overrun, 0);

    // R7 length above 32 clamps; dropped byte must not appear (R3)
    run_fixed(45, 1, "R7 clamp 45->32");
    chk(err_underrun == 1'b0, "R7 no underrun on clamp", err_underrun, 0);

    // R5/R6/R7 random fixed frames with carried-over bits
    for (int t = 0; t < 24; t++) begin
      int len = $urandom_range(1, 32);
      int div = $urandom_range(0, 3);
      while (exp_q.size() < len && s_ready) push_byte(8'($urandom));
      if (s_ready && ($urandom_range(0, 1) == 1)) push_byte(8'($urandom));
      run_fixed(len, div, "R5 random frame");
    end
    chk(err_underrun == 1'b0, "R8 no spurious underrun", err_underrun, 0);

    // drain leftovers
    if (exp_q.size() > 0) run_fixed(exp_q.size(), 0, "R7 drain");

    // R4 go during a frame is ignored
    push_byte(8'h3C); push_byte(8'hC3);
    done_cnt = 0;
    cap_q.delete();
    cfg_len = 6'd16; cfg_div = 8'd2; cur_div = 2;
    pulse_go();
    repeat (20) @(negedge clk);
    go = 1'b1; @(negedge clk); go = 1'b0;
    wait_done();
    repeat (30) @(negedge clk);
    chk(done_cnt == 1, "R4 single frame", done_cnt, 1);
    chk(cap_q.size() == 16 && !busy, "R4 bits sent", cap_q.size(), 16);
    exp_q.delete();

    // R8 fixed frame underrun: 8 data bits then ones
    push_byte(8'h96);
    begin
      bit expv[$];
      cap_q.delete();
      cfg_len = 6'd12; cfg_div = 8'd1; cur_div = 1;
      for (int i = 0; i < 12; i++) expv.push_back(i < 8 ? exp_q.pop_front() : 1'b1);
      done_cnt = 0;
      pulse_go();
      wait_done();
      cmp_bits("R8 underrun fill ones", expv);
      chk(err_underrun == 1'b1, "R8 underrun flag", err_underrun, 1);
      chk(done_cnt == 1, "R12 done once", done_cnt, 1);
    end
    @(negedge clk); clr_underrun = 1'b1; @(negedge clk); clr_underrun = 1'b0;
    chk(err_underrun == 1'b0, "R11 underrun cleared", err_underrun, 0);

    // R9 streaming with refills, normal end via stream_en low
    begin
      bit expv[$];
      int sent = 4;
      cap_q.delete(); per_bad = 0;
      for (int i = 0; i < 4; i++) push_byte(8'($urandom));
      cfg_len = 6'd0; cfg_div = 8'd3; cur_div = 3;
      stream_en = 1'b1;
      pulse_go();
      while (sent < 12) begin
        @(negedge clk);
        if (s_ready) begin push_byte(8'($urandom)); sent++; end
      end
      chk(busy == 1'b1, "R9 still streaming", busy, 1);
      stream_en = 1'b0;
      foreach (exp_q[i]) expv.push_back(exp_q[i]);
      exp_q.delete();
      wait_done();
      cmp_bits("R9 stream bits", expv);
      chk(per_bad == 0, "R6 stream period", per_bad, 0);
      chk(err_underrun == 1'b0, "R10 clean stream end", err_underrun, 0);
      chk(fill_level == 0, "R9 drained", fill_level, 0);
    end

    // R10 starved stream
    push_byte(8'h5A);
    begin
      bit expv[$];
      cap_q.delete();
      foreach (exp_q[i]) expv.push_back(exp_q[i]);
      exp_q.delete();
      cfg_len = 6'd0; cfg_div = 8'd0; cur_div = 0;
      stream_en = 1'b1;
      pulse_go();
      wait_done();
      stream_en = 1'b0;
      cmp_bits("R10 starved bits", expv);
      chk(err_underrun == 1'b1, "R10 underrun flag", err_underrun, 1);
    end

    // R11 set wins over clear in the same cycle
    @(negedge clk); s_valid = 1'b0;
    for (int i = 0; i < 4; i++) push_byte(8'h00);
    @(negedge clk); s_valid = 1'b1; clr_overrun = 1'b1;
    @(negedge clk); s_valid = 1'b0; clr_overrun = 1'b0;
    chk(err_overrun == 1'b1, "R11 set beats clear", err_overrun, 1);

    // R6 bit clock quiet outside frames
    chk(idle_viol == 0, "R6 tx_clk idle", idle_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule